// File: doc/BRIEF.md
# Integer Execute Stage

This block is the integer arithmetic and logic stage of a 32-bit load-store processor pipeline. Each cycle it receives the two register operands, the 16-bit immediate field, the 5-bit shift count and a 4-bit operation code from decode. When `use_imm` is set, the immediate stands in for the second operand. The block extends that immediate by the rule the operation calls for. It computes one of fourteen operations and registers the 32-bit result and an overflow flag, so both appear one clock after the inputs.

Add and subtract come in two forms. The trapping form raises `overflow` on two's-complement overflow. The non-trapping form gives the same result bits and never raises it. The trap itself is left to the exception logic downstream. Multiply, divide, branch resolution and the register file belong to other blocks.

Top module: `exu_core`

## Requirements
- R1: With op 0 (add) or 1 (addu), `result` is the 32-bit wrapped sum of operand A and the second operand. With op 2 (sub) or 3 (subu), it is A minus the second operand, wrapped.
- R2: With op 0 or 2, `overflow` is 1 exactly when the true signed result lies outside -2^31 .. 2^31-1.
- R3: With op 1 or 3, and with every other op code that is not 0 or 2, `overflow` is 0.
- R4: Op 4 gives bitwise AND, op 5 OR, op 6 XOR and op 7 NOR of A and the second operand.
- R5: With `use_imm`=1 the second operand is the immediate. It is zero-extended for ops 4 to 7 and sign-extended from bit 15 for every other op. With `use_imm`=0 it is `src_b`.
- R6: Op 8 shifts A left and op 9 shifts A right, each by `shamt` positions, filling vacated bits with 0.
- R7: Op 10 shifts A right by `shamt` positions and fills the vacated bits with A bit 31.
- R8: Op 11 gives 1 if A is less than the second operand as signed numbers, otherwise 0. Op 12 does the same comparison as unsigned numbers, using the sign-extended immediate when `use_imm`=1.
- R9: Op 13 gives `imm16` in bits 31..16 and zero in bits 15..0.
- R10: Op codes 14 and 15 give `result` 0 and `overflow` 0.
- R11: `result` and `overflow` update on the rising clock edge after the inputs are applied. While `rst_n` is low at an edge, both become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code (see requirements) |
| use_imm | input | 1 | Take the extended immediate as second operand |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Shift count |
| result | output | 32 | Registered result |
| overflow | output | 1 | Registered signed-overflow flag |

## Verification
The hardest cases to reach from the ports sit at the edges of the signed range. Overflow must flip exactly at 0x7FFFFFFF + 1 and at 0x80000000 - 1, and subtracting 0x80000000 must be handled correctly. The unsigned compare with an immediate must also see a negative immediate as a very large unsigned value. Uniform random operands almost never land on these points, so the stimulus drives them directly: fixed pairs around both range ends for every add and subtract form, and immediates with bit 15 set for every op that extends. A long run of random operations then covers the rest, with operands biased toward the extreme values.

// File: rtl/exu_pkg.sv
// Package: shared operation codes for the integer execute stage.
// Assumes a 4-bit operation code supplied by decode; codes 14 and 15 unused.
package exu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_SLT  = 4'd11,
        OP_SLTU = 4'd12,
        OP_LUI  = 4'd13
    } exu_op_e;

    // True for the bitwise group, whose immediates are zero-extended.
    function automatic logic is_logical(input logic [3:0] code);
        return (code >= 4'd4) && (code <= 4'd7);
    endfunction

endpackage

// File: rtl/exu_immext.sv
// Module: immediate extender.
// Widens an IW-bit immediate to W bits, either with zeros or with copies of
// its top bit. Assumes W > IW.
module exu_immext #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [IW-1:0] imm,
    input  logic          zero_ext,
    output logic [W-1:0]  ext
);
    localparam int PAD = W - IW;

    // Select fill bit from the requested extension rule.
    logic fill;
    assign fill = zero_ext ? 1'b0 : imm[IW-1];
    assign ext  = {{PAD{fill}}, imm};
endmodule

// File: rtl/exu_addsub.sv
// Module: adder/subtractor with signed overflow detection.
// Subtraction adds the inverted operand plus one. Overflow means both
// addends share a sign that the sum does not.
module exu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    // Condition the second addend for subtraction.
    assign b_eff = sub ? ~b : b;
    // Carry-in supplies the +1 of the two's complement.
    assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    // Same-sign addends whose sum changed sign.
    assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/exu_shifter.sv
// Module: logarithmic barrel shifter.
// One stage per bit of the shift count. Left shifts reuse the right-shift
// stages by reversing the bit order on entry and exit. Arithmetic fill
// applies to right shifts only.
module exu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stg [SW+1];
    logic         fill;

    // Fill bit: sign only for arithmetic right shifts.
    assign fill = arith && !left && din[W-1];

    for (genvar k = 0; k < W; k++) begin : g_rev
        assign rev_in[k]  = din[W-1-k];
        assign rev_out[k] = stg[SW][W-1-k];
    end

    assign stg[0] = left ? rev_in : din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        // Shift right by 2^i when this count bit is set.
        assign stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][W-1:STEP]} : stg[i];
    end

    assign dout = left ? rev_out : stg[SW];
endmodule

// File: rtl/exu_core.sv
// Module: integer execute stage, top level.
// Selects the second operand (register or extended immediate), computes the
// chosen operation and registers result and overflow. Assumes op_sel comes
// from decode already; unused codes produce zero.
module exu_core
    import exu_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic          use_imm,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [IW-1:0] imm16,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  result,
    output logic          overflow
);
    localparam int LO = W - IW;

    logic [W-1:0] imm_ext;
    logic [W-1:0] opnd_b;
    logic [W-1:0] as_sum;
    logic         as_ovf;
    logic         as_sub;
    logic [W-1:0] sh_out;
    logic         sh_left;
    logic         sh_arith;
    logic [W-1:0] nxt_res;
    logic         nxt_ovf;

    exu_immext #(.W(W), .IW(IW)) u_ext (
        .imm      (imm16),
        .zero_ext (is_logical(op_sel)),
        .ext      (imm_ext)
    );

    assign opnd_b = use_imm ? imm_ext : src_b;

    assign as_sub = (op_sel == OP_SUB) || (op_sel == OP_SUBU);

    exu_addsub #(.W(W)) u_addsub (
        .a   (src_a),
        .b   (opnd_b),
        .sub (as_sub),
        .sum (as_sum),
        .ovf (as_ovf)
    );

    assign sh_left  = (op_sel == OP_SLL);
    assign sh_arith = (op_sel == OP_SRA);

    exu_shifter #(.W(W), .SW(SW)) u_shift (
        .din   (src_a),
        .amt   (shamt),
        .left  (sh_left),
        .arith (sh_arith),
        .dout  (sh_out)
    );

    // Pick the result for the current operation code.
    always_comb begin
        nxt_res = '0;
        nxt_ovf = 1'b0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                nxt_res = as_sum;
                nxt_ovf = as_ovf;
            end
            OP_ADDU, OP_SUBU: nxt_res = as_sum;
            OP_AND:  nxt_res = src_a & opnd_b;
            OP_OR:   nxt_res = src_a | opnd_b;
            OP_XOR:  nxt_res = src_a ^ opnd_b;
            OP_NOR:  nxt_res = ~(src_a | opnd_b);
            OP_SLL, OP_SRL, OP_SRA: nxt_res = sh_out;
            OP_SLT:  nxt_res = {{(W-1){1'b0}}, ($signed(src_a) < $signed(opnd_b))};
            OP_SLTU: nxt_res = {{(W-1){1'b0}}, (src_a < opnd_b)};
            OP_LUI:  nxt_res = {imm16, {LO{1'b0}}};
            default: begin
                nxt_res = '0;
                nxt_ovf = 1'b0;
            end
        endcase
    end

    // Stage register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            overflow <= 1'b0;
        end else begin
            result   <= nxt_res;
            overflow <= nxt_ovf;
        end
    end
endmodule

// File: rtl/exu_core_chk.sv
// Module: property checker for the execute stage, bound to exu_core.
// Relates each registered output to the inputs of the previous cycle.
module exu_core_chk #(
    parameter int W  = 32,
    parameter int IW = 16,
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_sel,
    input logic          use_imm,
    input logic [W-1:0]  src_a,
    input logic [IW-1:0] imm16,
    input logic [W-1:0]  result,
    input logic          overflow
);
    localparam int LO = W - IW;

    // R3: only trapping add/sub may raise overflow.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_sel) != 4'd0) && ($past(op_sel) != 4'd2)) |-> !overflow);

    // R10: unused codes give zero.
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_sel) >= 4'd14) |-> (result == '0));

    // R8: compares produce only 0 or 1.
    assert_slt_bool_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_sel) == 4'd11) || ($past(op_sel) == 4'd12)) |-> (result[W-1:1] == '0));

    // R9: upper-immediate load places the field high.
    assert_lui_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_sel) == 4'd13) |-> (result == {$past(imm16), {LO{1'b0}}}));

    // R5: AND with an immediate cannot set the upper bits.
    assert_andi_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_sel) == 4'd4) && $past(use_imm)) |-> (result[W-1:IW] == '0));

    // R7: shifting a negative value arithmetically keeps the sign.
    assert_sra_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_sel) == 4'd10) && $past(src_a[W-1])) |-> result[W-1]);
endmodule

bind exu_core exu_core_chk #(.W(W), .IW(IW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .use_imm  (use_imm),
    .src_a    (src_a),
    .imm16    (imm16),
    .result   (result),
    .overflow (overflow)
);

// File: tb/tb_exu_core.sv
`timescale 1ns/1ps
module tb_exu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic        use_imm = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        overflow;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    exu_core dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
        .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
        .result(result), .overflow(overflow)
    );

    // Behavioural reference built from the requirement text.
    function automatic void model(input logic [3:0] op, input logic ui,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [15:0] im, input logic [4:0] sh,
                                  output logic [31:0] r, output logic o);
        logic [31:0] bx;
        longint s;
        bit logical;
        logical = (op >= 4) && (op <= 7);
        if (ui) bx = logical ? {16'h0, im} : {{16{im[15]}}, im};
        else    bx = b;
        r = 0; o = 0;
        case (op)
            0, 1: begin
                s = longint'($signed(a)) + longint'($signed(bx));
                r = a + bx;
                o = (op == 0) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
            end
            2, 3: begin
                s = longint'($signed(a)) - longint'($signed(bx));
                r = a - bx;
                o = (op == 2) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
            end
            4: r = a & bx;
            5: r = a | bx;
            6: r = a ^ bx;
            7: r = ~(a | bx);
            8: r = a << sh;
            9: r = a >> sh;
            10: r = $unsigned($signed(a) >>> sh);
            11: r = ($signed(a) < $signed(bx)) ? 32'd1 : 32'd0;
            12: r = (a < bx) ? 32'd1 : 32'd0;
            13: r = {im, 16'h0};
            default: begin r = 0; o = 0; end
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] op, input logic ui);
        if (ui && op != 13 && op < 14 && !(op >= 8 && op <= 10)) return "R5";
        case (op)
            0, 2: return "R2";
            1, 3: return "R3";
            4, 5, 6, 7: return "R4";
            8, 9: return "R6";
            10: return "R7";
            11, 12: return "R8";
            13: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic void check(input string tag, input logic [31:0] er, input logic eo);
        n_run++;
        if (result !== er || overflow !== eo) begin
            n_fail++;
            $display("FAIL %s: op=%0d result=%h ovf=%b expected result=%h ovf=%b",
                     tag, op_sel, result, overflow, er, eo);
        end
    endfunction

    // Drive one operation at the falling edge, check after the next rising edge.
    task automatic run_op(input logic [3:0] op, input logic ui, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] im,
                          input logic [4:0] sh, input string tag);
        logic [31:0] er;
        logic eo;
        @(negedge clk);
        op_sel = op; use_imm = ui; src_a = a; src_b = b; imm16 = im; shamt = sh;
        model(op, ui, a, b, im, sh, er, eo);
        @(posedge clk); #1;
        check(tag, er, eo);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        // R11: reset state.
        repeat (2) @(posedge clk);
        #1 check("R11", 32'h0, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R1 and R2: range-edge sums and differences.
        run_op(0, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, "R2");
        run_op(0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R2");
        run_op(0, 0, 32'h7FFF_FFFE, 32'h1, 0, 0, "R1");
        run_op(2, 0, 32'h8000_0000, 32'h1, 0, 0, "R2");
        run_op(2, 0, 32'h0, 32'h8000_0000, 0, 0, "R2");
        run_op(2, 0, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, "R1");
        run_op(1, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, "R3");
        run_op(3, 0, 32'h8000_0000, 32'h1, 0, 0, "R3");
        // R5: immediate forms with bit 15 set.
        run_op(0, 1, 32'h10, 0, 16'hFFFF, 0, "R5");
        run_op(0, 1, 32'h7FFF_FFFF, 0, 16'h0001, 0, "R5");
        run_op(5, 1, 32'h0, 0, 16'h8001, 0, "R5");
        run_op(4, 1, 32'hFFFF_FFFF, 0, 16'hF0F0, 0, "R5");
        run_op(6, 1, 32'hFFFF_0000, 0, 16'hFFFF, 0, "R5");
        run_op(12, 1, 32'h7FFF_0000, 0, 16'h8000, 0, "R8");
        run_op(11, 1, 32'h0, 0, 16'h8000, 0, "R8");
        // R4: bitwise group.
        run_op(7, 0, 32'h0F0F_0000, 32'h0000_00FF, 0, 0, "R4");
        run_op(6, 0, 32'hDEAD_BEEF, 32'hFFFF_0000, 0, 0, "R4");
        // R6 / R7: shift extremes.
        run_op(8, 0, 32'h8000_0001, 0, 0, 5'd31, "R6");
        run_op(9, 0, 32'h8000_0000, 0, 0, 5'd31, "R6");
        run_op(10, 0, 32'h8000_0000, 0, 0, 5'd31, "R7");
        run_op(10, 0, 32'h4000_0000, 0, 0, 5'd4, "R7");
        run_op(9, 0, 32'hF000_000F, 0, 0, 5'd0, "R6");
        // R8: signed versus unsigned disagreement.
        run_op(11, 0, 32'hFFFF_FFFF, 32'h1, 0, 0, "R8");
        run_op(12, 0, 32'hFFFF_FFFF, 32'h1, 0, 0, "R8");
        run_op(11, 0, 32'h5, 32'h5, 0, 0, "R8");
        // R9, R10.
        run_op(13, 0, 32'h1234_5678, 0, 16'hABCD, 0, "R9");
        run_op(14, 0, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 5'd3, "R10");
        run_op(15, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd7, "R10");

        // Mixed random sweep.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic ui;
            op = 4'($urandom_range(0, 15));
            ui = 1'($urandom_range(0, 1));
            run_op(op, ui, pick_val(), pick_val(), 16'($urandom()), 5'($urandom()),
                   tag_for(op, ui));
        end

        // R11: reset mid-run clears outputs.
        @(negedge clk);
        op_sel = 0; use_imm = 0; src_a = 32'h7FFF_FFFF; src_b = 32'h1; rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11", 32'h0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #1ms;
                n_run++;
                n_fail++;
                $display("FAIL R11: watchdog expired result=%h expected completion", result);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule